// File: doc/BRIEF.md
# Parallel NOR flash command interpreter

This block behaves like a small parallel NOR flash device on a simple synchronous bus. It has a byte address, 16-bit write data, a write strobe and a read strobe. Storage is a byte array split into uniform erase sectors. The byte array is held as little-endian 16-bit words, and address bit 0 is ignored.

Writes are not plain stores. Each write is decoded as one step of a command sequence: word program, sector erase with confirm, buffered block write, status read and clear, identifier read, lock/unlock, and a query table. The active command decides what a later read returns. A read can return array data, the status word, an identifier word or a query-table byte.

Operations finish at once. There is no programming or erase delay, no suspend, no write protection and no lock enforcement. Status bit 7 is the only status bit that is used: it reads as "ready".

Top module: `nor_flash_ctl`

## Requirements
- R1: After reset every array word reads 0xFFFF, the block is in array-read mode, and the status word is 0x0000.
- R2: A read strobe at byte address A loads rdata_o at the next clock edge. The value is the word at A with bit 0 dropped: the byte at the even address is in bits 7:0 and the byte at the odd address is in bits 15:8. rdata_o holds its value in cycles with no read strobe.
- R3: Writing command 0x10 or 0x40 (low byte of the write data) arms a program. The next write stores its 16-bit data at its address, sets ready (status bit 7), and returns the block to array-read mode.
- R4: Command 0x20 at address A fills the whole sector holding A with 0xFF at once (sector base = A with its low log2(sector size) bits cleared) and sets ready. A following 0xD0 confirms and leaves the block in status-read mode. A following 0xFF goes back to array-read mode, but the erase is not undone.
- R5: Command 0xE8 sets ready. The next write gives a word count N. The next N+1 writes each store one word at their own address. A following 0xD0 ends the sequence with ready set and the block in status-read mode. Any other value in that last step returns the block to array-read mode.
- R6: After an erase, a lock, a status request (0x70) or a buffered write is started, and until another command is decoded, every read returns 0x0080 when ready is set and 0x0000 when it is clear.
- R7: Command 0x50 clears the whole status word and returns the block to array-read mode.
- R8: After command 0x90, reads return an identifier chosen by the word index addr[7:1]. Index 0 gives the manufacturer code, index 1 gives the device code, and any other index gives 0. Address bits above bit 7 are ignored.
- R9: After command 0x98, a read at word index addr[7:1] returns the query byte, zero-extended. Index 0x10 to 0x12 hold "QRY", 0x13 holds 0x01 and 0x15 holds 0x31. Index 0x27 holds log2 of the array size and 0x2A holds log2 of the buffered-write block size. Index 0x2C holds 1, index 0x2D/0x2E hold the sector count minus one, and index 0x2F/0x30 hold the sector size shifted right by 8. Other indices below 0x31 hold 0, and indices from 0x31 up read 0. In query mode, a write of 0xFF returns to array-read mode and any other write is ignored.
- R10: Command 0x60 arms lock/unlock. A following 0xD0 or 0x01 sets ready and leaves the block in status-read mode. Any other value returns the block to array-read mode, and the array is unchanged.
- R11: An unrecognised command, or an invalid second step of an erase, returns the block to array-read mode. A command write never changes array contents, except for the erase described in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Write strobe, one command step or data word per cycle |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 16 | Write data; its low byte is the command |
| rdata_o | output | 16 | Read data, registered one cycle after rd_i |

## Verification
The assertions assume that wr_i and rd_i are never high in the same cycle. This means a read always reflects the mode and status that were in force before the edge. The stimulus meets this because every bus access takes one strobe cycle followed by one idle cycle, with writes and reads issued by separate tasks. The assertions also assume that address bit 0 is ignored and that every write in a sequence is one full word. The bench only ever drives whole 16-bit words.

// File: rtl/nor_flash_pkg.sv
package nor_flash_pkg;

  typedef enum logic [3:0] {
    M_ARRAY, M_PROG, M_ERASE_CONF, M_ERASE_DONE, M_LOCK_CONF, M_LOCK_DONE,
    M_STATUS, M_ID, M_QUERY, M_BUF_CNT, M_BUF_DATA, M_BUF_CONF, M_BUF_DONE
  } mode_e;

  localparam logic [7:0] C_PROG_A  = 8'h10;
  localparam logic [7:0] C_PROG_B  = 8'h40;
  localparam logic [7:0] C_ERASE   = 8'h20;
  localparam logic [7:0] C_CLR     = 8'h50;
  localparam logic [7:0] C_LOCK    = 8'h60;
  localparam logic [7:0] C_STAT    = 8'h70;
  localparam logic [7:0] C_ID      = 8'h90;
  localparam logic [7:0] C_QUERY   = 8'h98;
  localparam logic [7:0] C_BUF     = 8'hE8;
  localparam logic [7:0] C_CONFIRM = 8'hD0;
  localparam logic [7:0] C_UNLOCK  = 8'h01;
  localparam logic [7:0] C_RESET   = 8'hFF;

  // modes in which the next write is decoded as a fresh command
  function automatic logic is_idle(mode_e m);
    return m inside {M_ARRAY, M_STATUS, M_ID, M_ERASE_DONE, M_LOCK_DONE, M_BUF_DONE};
  endfunction

  function automatic logic is_status_mode(mode_e m);
    return m inside {M_ERASE_CONF, M_ERASE_DONE, M_LOCK_CONF, M_LOCK_DONE, M_STATUS,
                     M_BUF_CNT, M_BUF_DATA, M_BUF_CONF, M_BUF_DONE};
  endfunction

endpackage

// File: rtl/nor_query_rom.sv
module nor_query_rom #(
  parameter int ARRAY_BYTES  = 4096,
  parameter int SECTOR_BYTES = 1024,
  parameter int BUF_BYTES    = 32,
  parameter int IDX_W        = 7
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       q_o
);
  localparam int NSECT_M1 = ARRAY_BYTES / SECTOR_BYTES - 1;
  localparam int Q_LEN    = 'h31;

  always_comb begin
    q_o = 8'h00;
    if (int'(idx_i) < Q_LEN) begin
      case (int'(idx_i))
        'h10: q_o = 8'h51;
        'h11: q_o = 8'h52;
        'h12: q_o = 8'h59;
        'h13: q_o = 8'h01;
        'h15: q_o = 8'h31;
        'h27: q_o = 8'($clog2(ARRAY_BYTES));
        'h2A: q_o = 8'($clog2(BUF_BYTES));
        'h2C: q_o = 8'h01;
        'h2D: q_o = 8'(NSECT_M1);
        'h2E: q_o = 8'(NSECT_M1 >> 8);
        'h2F: q_o = 8'(SECTOR_BYTES >> 8);
        'h30: q_o = 8'(SECTOR_BYTES >> 16);
        default: q_o = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/nor_flash_array.sv
module nor_flash_array #(
  parameter int DATA_W       = 16,
  parameter int ARRAY_BYTES  = 4096,
  parameter int SECTOR_BYTES = 1024
) (
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic                                      prog_i,
  input  logic                                      erase_i,
  input  logic [$clog2(ARRAY_BYTES)-1:0]            addr_i,
  input  logic [DATA_W-1:0]                         wdata_i,
  output logic [DATA_W-1:0]                         rword_o
);
  localparam int ADDR_W   = $clog2(ARRAY_BYTES);
  localparam int BYTE_SH  = $clog2(DATA_W / 8);
  localparam int WORDS    = ARRAY_BYTES / (DATA_W / 8);
  localparam int SECT_LOG = $clog2(SECTOR_BYTES);
  localparam int SECT_W   = ADDR_W - SECT_LOG;
  localparam int WSECT_SH = SECT_LOG - BYTE_SH;

  logic [DATA_W-1:0]       mem [WORDS];
  logic [ADDR_W-BYTE_SH-1:0] widx;
  logic [SECT_W-1:0]       sect;

  assign widx    = addr_i[ADDR_W-1:BYTE_SH];
  assign sect    = addr_i[ADDR_W-1:SECT_LOG];
  assign rword_o = mem[widx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (erase_i) begin
      for (int i = 0; i < WORDS; i++)
        if (SECT_W'(i >> WSECT_SH) == sect) mem[i] <= '1;
    end else if (prog_i) begin
      mem[widx] <= wdata_i;
    end
  end
endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_flash_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output mode_e             mode_o,
  output logic              ready_o,
  output logic [DATA_W-1:0] buf_cnt_o,
  output logic              prog_o,
  output logic              erase_o
);
  mode_e             mode_q, mode_d;
  logic              ready_q, ready_d;
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic [7:0]        cmd;

  assign cmd = wdata_i[7:0];

  always_comb begin
    mode_d  = mode_q;
    ready_d = ready_q;
    cnt_d   = cnt_q;
    prog_o  = 1'b0;
    erase_o = 1'b0;
    if (wr_i) begin
      if (is_idle(mode_q)) begin
        case (cmd)
          C_PROG_A, C_PROG_B: mode_d = M_PROG;
          C_ERASE: begin erase_o = 1'b1; ready_d = 1'b1; mode_d = M_ERASE_CONF; end
          C_CLR:   begin ready_d = 1'b0; mode_d = M_ARRAY; end
          C_LOCK:  mode_d = M_LOCK_CONF;
          C_STAT:  mode_d = M_STATUS;
          C_ID:    mode_d = M_ID;
          C_QUERY: mode_d = M_QUERY;
          C_BUF:   begin ready_d = 1'b1; mode_d = M_BUF_CNT; end
          default: mode_d = M_ARRAY;
        endcase
      end else begin
        case (mode_q)
          M_PROG: begin prog_o = 1'b1; ready_d = 1'b1; mode_d = M_ARRAY; end
          M_ERASE_CONF:
            if (cmd == C_CONFIRM) begin ready_d = 1'b1; mode_d = M_ERASE_DONE; end
            else mode_d = M_ARRAY;
          M_LOCK_CONF:
            if (cmd == C_CONFIRM || cmd == C_UNLOCK) begin
              ready_d = 1'b1; mode_d = M_LOCK_DONE;
            end else mode_d = M_ARRAY;
          M_QUERY: if (cmd == C_RESET) mode_d = M_ARRAY;
          M_BUF_CNT: begin cnt_d = wdata_i; mode_d = M_BUF_DATA; end
          M_BUF_DATA: begin
            prog_o  = 1'b1;
            ready_d = 1'b1;
            cnt_d   = cnt_q - 1'b1;
            if (cnt_q == '0) mode_d = M_BUF_CONF;
          end
          M_BUF_CONF:
            if (cmd == C_CONFIRM) begin ready_d = 1'b1; mode_d = M_BUF_DONE; end
            else mode_d = M_ARRAY;
          default: mode_d = M_ARRAY;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= M_ARRAY;
      ready_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      mode_q  <= mode_d;
      ready_q <= ready_d;
      cnt_q   <= cnt_d;
    end
  end

  assign mode_o    = mode_q;
  assign ready_o   = ready_q;
  assign buf_cnt_o = cnt_q;
endmodule

// File: rtl/nor_flash_ctl.sv
module nor_flash_ctl
  import nor_flash_pkg::*;
#(
  parameter int          DATA_W       = 16,
  parameter int          ARRAY_BYTES  = 4096,
  parameter int          SECTOR_BYTES = 1024,
  parameter int          BUF_BYTES    = 32,
  parameter logic [15:0] MANUF_ID     = 16'h00A5,
  parameter logic [15:0] DEVICE_ID    = 16'h5A17,
  localparam int         ADDR_W       = $clog2(ARRAY_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int BYTE_SH = $clog2(DATA_W / 8);
  localparam int IDX_W   = 8 - BYTE_SH;

  mode_e             mode;
  logic              ready;
  logic [DATA_W-1:0] buf_cnt;
  logic              prog, erase;
  logic [DATA_W-1:0] rword;
  logic [IDX_W-1:0]  idx;
  logic [7:0]        qbyte;

  assign idx = addr_i[7:BYTE_SH];

  nor_cmd_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk_i, .rst_ni, .wr_i, .wdata_i,
    .mode_o(mode), .ready_o(ready), .buf_cnt_o(buf_cnt),
    .prog_o(prog), .erase_o(erase)
  );

  nor_flash_array #(
    .DATA_W(DATA_W), .ARRAY_BYTES(ARRAY_BYTES), .SECTOR_BYTES(SECTOR_BYTES)
  ) u_array (
    .clk_i, .rst_ni, .prog_i(prog), .erase_i(erase),
    .addr_i, .wdata_i, .rword_o(rword)
  );

  nor_query_rom #(
    .ARRAY_BYTES(ARRAY_BYTES), .SECTOR_BYTES(SECTOR_BYTES),
    .BUF_BYTES(BUF_BYTES), .IDX_W(IDX_W)
  ) u_query (
    .idx_i(idx), .q_o(qbyte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (rd_i) begin
      if (is_status_mode(mode)) begin
        rdata_o <= DATA_W'({ready, 7'b0});
      end else if (mode == M_ID) begin
        if (idx == '0)                rdata_o <= DATA_W'(MANUF_ID);
        else if (idx == IDX_W'(1))    rdata_o <= DATA_W'(DEVICE_ID);
        else                          rdata_o <= '0;
      end else if (mode == M_QUERY) begin
        rdata_o <= DATA_W'(qbyte);
      end else begin
        rdata_o <= rword;
      end
    end
  end
endmodule

// File: rtl/nor_flash_ctl_chk.sv
module nor_flash_ctl_chk
  import nor_flash_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] wdata_i,
  input mode_e             mode,
  input logic              ready,
  input logic [DATA_W-1:0] buf_cnt,
  input logic [DATA_W-1:0] rdata_o
);
  a_r2_hold_without_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  a_r3_prog_completes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && mode == M_PROG |=> ready && mode == M_ARRAY);

  a_r4_erase_sets_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && is_idle(mode) && wdata_i[7:0] == 8'h20 |=> ready && mode == M_ERASE_CONF);

  a_r5_last_word_to_confirm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && mode == M_BUF_DATA && buf_cnt == '0 |=> mode == M_BUF_CONF);

  a_r6_status_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !wr_i && is_status_mode(mode) |=> rdata_o == DATA_W'({$past(ready), 7'b0}));

  a_r7_clear_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && is_idle(mode) && wdata_i[7:0] == 8'h50 |=> !ready && mode == M_ARRAY);
endmodule

bind nor_flash_ctl nor_flash_ctl_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i), .wdata_i(wdata_i),
  .mode(mode), .ready(ready), .buf_cnt(buf_cnt), .rdata_o(rdata_o)
);

// File: tb/test_nor_flash_ctl.sv
module test_nor_flash_ctl;
  localparam int ARRAY_BYTES  = 4096;
  localparam int SECTOR_BYTES = 1024;
  localparam int BUF_BYTES    = 32;
  localparam int WORDS        = ARRAY_BYTES / 2;
  localparam logic [15:0] MANUF = 16'h00A5;
  localparam logic [15:0] DEVID = 16'h5A17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;

  int n_chk = 0;
  int n_err = 0;
  logic [15:0] ref_w [WORDS];

  always #10 clk = ~clk;

  nor_flash_ctl i_nor_flash_ctl (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %04h expected %04h", req, act, exp);
    end
  endtask

  task automatic fw(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic fr(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic rchk(input string req, input logic [11:0] a, input logic [15:0] exp);
    logic [15:0] d;
    fr(a, d);
    chk(req, d, exp);
  endtask

  task automatic ref_erase(input logic [11:0] a);
    int base = (int'(a) / SECTOR_BYTES) * (SECTOR_BYTES / 2);
    for (int i = 0; i < SECTOR_BYTES / 2; i++) ref_w[base + i] = 16'hFFFF;
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < WORDS; i++) rchk(req, 12'(i * 2), ref_w[i]);
  endtask

  function automatic logic [15:0] q_exp(input int i);
    case (i)
      'h10: return 16'h0051;
      'h11: return 16'h0052;
      'h12: return 16'h0059;
      'h13: return 16'h0001;
      'h15: return 16'h0031;
      'h27: return 16'd12;
      'h2A: return 16'd5;
      'h2C: return 16'h0001;
      'h2D: return 16'(ARRAY_BYTES / SECTOR_BYTES - 1);
      'h2F: return 16'(SECTOR_BYTES / 256);
      default: return 16'h0000;
    endcase
  endfunction

  initial begin
    #(20 * 200000);
    n_err++;
    $display("FAIL watchdog: got hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < WORDS; i++) ref_w[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    sweep("R1 erased array");
    fw(0, 16'h0070); rchk("R1 status at reset", 0, 16'h0000);

    fw(0, 16'h0040); fw(12'h010, 16'h1234); ref_w[12'h010 >> 1] = 16'h1234;
    fw(0, 16'h0010); fw(12'h7FE, 16'hBEEF); ref_w[12'h7FE >> 1] = 16'hBEEF;
    rchk("R3 program 0x40", 12'h010, 16'h1234);
    rchk("R2 odd byte address", 12'h011, 16'h1234);
    rchk("R3 program 0x10", 12'h7FE, 16'hBEEF);
    fw(0, 16'h0070); rchk("R6 ready after program", 0, 16'h0080);
    fw(0, 16'h0050); rchk("R7 array after clear", 12'h010, 16'h1234);
    fw(0, 16'h0070); rchk("R7 status cleared", 0, 16'h0000);

    fw(12'h456, 16'h0020); ref_erase(12'h456);
    rchk("R4 status after erase", 12'h010, 16'h0080);
    fw(0, 16'h00D0); rchk("R4 status after confirm", 12'h7FE, 16'h0080);
    fw(0, 16'h00FF); rchk("R4 sector erased", 12'h7FE, 16'hFFFF);
    rchk("R4 other sector kept", 12'h010, 16'h1234);

    fw(0, 16'h0040); fw(12'h900, 16'hCAFE); ref_w[12'h900 >> 1] = 16'hCAFE;
    rchk("R3 program sector 2", 12'h900, 16'hCAFE);
    fw(12'h9AA, 16'h0020); ref_erase(12'h9AA);
    fw(0, 16'h00FF); rchk("R4 erase stands after abort", 12'h900, 16'hFFFF);

    fw(0, 16'h0050);
    fw(12'hC00, 16'h00E8); rchk("R5 ready on buffer start", 0, 16'h0080);
    fw(12'hC00, 16'd3);
    for (int k = 0; k < 4; k++) begin
      fw(12'(12'hC00 + 2 * k), 16'(16'h1000 + k));
      ref_w[(12'hC00 >> 1) + k] = 16'(16'h1000 + k);
    end
    rchk("R5 status while confirming", 0, 16'h0080);
    fw(0, 16'h00D0); rchk("R5 status after confirm", 0, 16'h0080);
    fw(0, 16'h00FF);
    for (int k = 0; k < 5; k++)
      rchk("R5 buffered words", 12'(12'hC00 + 2 * k), ref_w[(12'hC00 >> 1) + k]);

    fw(12'hE00, 16'h00E8); fw(0, 16'd0);
    fw(12'hE00, 16'h7777); ref_w[12'hE00 >> 1] = 16'h7777;
    fw(0, 16'h0012); rchk("R5 bad confirm to array", 12'hE00, 16'h7777);

    fw(0, 16'h0090);
    for (int i = 0; i < 128; i++)
      rchk("R8 id index", 12'(12'h300 + 2 * i), (i == 0) ? MANUF : (i == 1) ? DEVID : 16'h0000);

    fw(0, 16'h0098);
    for (int i = 0; i < 128; i++) rchk("R9 query index", 12'(2 * i), q_exp(i));
    fw(0, 16'h0000); rchk("R9 query kept", 12'h020, 16'h0051);
    fw(0, 16'h00FF); rchk("R9 query left", 12'h010, 16'h1234);

    fw(0, 16'h0050);
    fw(0, 16'h0060); rchk("R10 status during lock", 0, 16'h0000);
    fw(0, 16'h0001); rchk("R10 unlock ready", 0, 16'h0080);
    fw(0, 16'h0060); fw(12'h010, 16'h0033); rchk("R10 bad lock to array", 12'h010, 16'h1234);
    fw(0, 16'h0060); fw(0, 16'h00D0); rchk("R10 lock ready", 0, 16'h0080);

    fw(12'h900, 16'h0077); rchk("R11 unknown cmd", 12'h900, 16'hFFFF);
    fw(12'h000, 16'h0020); ref_erase(12'h000);
    fw(0, 16'h0055); rchk("R11 bad erase step", 12'h010, 16'hFFFF);

    sweep("R11 final array");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule